// File: doc/BRIEF.md
# Two-Level Direct-Indexed Prefix Lookup

This block resolves the longest matching route for an IPv4 destination address with at most two reads of on-chip tables and no searching. The top `HI_BITS` bits of the address index a first table. Each entry there carries a kind flag. The entry either holds the final next hop, or holds the number of a block in a second table. In the second case the following `LO_BITS` address bits pick one entry of that block, and that entry is the next hop. Routes no longer than `HI_BITS` are expanded into first-table entries. Each first-level prefix that has longer routes under it gets its own block of 2^`LO_BITS` entries in the second table. That expansion is done by software outside the block.

Lookups enter one per cycle and leave in order, three cycles later. The latency is the same whichever table gave the answer. A single write port loads either table. Until an entry of the first table has been written, it reads as a next hop equal to the `DEFAULT_HOP` parameter, so a table that has just come out of reset routes all traffic to the default route.

Top module: `dir_lpm`

## Requirements
- R1: After reset, every lookup returns `DEFAULT_HOP` until the first-table entry that the lookup indexes has been written.
- R2: A first-table entry whose flag bit `wr_data[ENTRY_W-1]` was written as 1 (bit 8 by default) is a next hop. A lookup whose address bits [31:32-HI_BITS] select that entry returns `wr_data[HOP_W-1:0]`.
- R3: A first-table entry whose flag bit was written as 0 is a pointer, held in `wr_data[PTR_W-1:0]`. The lookup then returns the second-table entry at index {pointer, address bits [31-HI_BITS:32-HI_BITS-LO_BITS]}.
- R4: A request accepted in cycle c produces `res_valid` high in cycle c+3 and only then, for both the first-table and the second-table path. Back-to-back requests are accepted every cycle and come back in order.
- R5: Address bits below bit 32-HI_BITS-LO_BITS have no effect on the result.
- R6: When a write to an entry happens in the same cycle as the read of that entry, the lookup returns the data held before the write. Later lookups see the new data.
- R7: `wr_sel` = 0 writes the first table at `wr_idx[HI_BITS-1:0]`. `wr_sel` = 1 writes the second table at `wr_idx[T2_AW-1:0]` with `wr_data[HOP_W-1:0]`. A write to one table leaves the other table unchanged.
- R8: `res_hop` holds its last value while `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Destination address to resolve |
| res_valid | output | 1 | Lookup result strobe |
| res_hop | output | HOP_W | Resolved next hop |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Table select: 0 first table, 1 second table |
| wr_idx | input | IDX_W | Entry index within the selected table |
| wr_data | input | ENTRY_W | First table: {flag, payload}; second table: hop in low bits |

## Verification
The bench probes the exact arrival cycle of the result for both paths, and it runs a stream with the two paths interleaved. A design that skipped the second-table stage for direct entries would deliver results a cycle early or out of order. The bench also writes an entry in the same cycle that the entry is looked up. A write-first memory would leak the new hop into that lookup. Low-address variation checks that the lower address bits have no effect, and an alias write to the second table, at an index that is numerically equal to a live first-table index, catches a broken table select. Untouched entries, read right after reset, would return garbage in a design that had no default-route fallback.

// File: rtl/dir_lpm_pkg.sv
package dir_lpm_pkg;

  typedef enum logic {
    TBL_FIRST  = 1'b0,
    TBL_SECOND = 1'b1
  } tbl_sel_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dir_lpm_ram.sv
// Simple dual-port RAM, read-before-write, registered read port.
module dir_lpm_ram #(
  parameter int DW = 8,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end

endmodule

// File: rtl/dir_lpm_stage1.sv
// First-table access: one read indexed by the upper address bits.
module dir_lpm_stage1 #(
  parameter int          HI_BITS     = 12,
  parameter int          LO_BITS     = 4,
  parameter int          ENTRY_W     = 9,
  parameter int unsigned DEFAULT_HOP = 0,
  localparam int PAY_W = ENTRY_W - 1,
  localparam int DEPTH = 1 << HI_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [HI_BITS-1:0] req_hi,
  input  logic [LO_BITS-1:0] req_lo,
  input  logic               t1_we,
  input  logic [HI_BITS-1:0] t1_widx,
  input  logic [ENTRY_W-1:0] t1_wdata,
  output logic               s1_valid,
  output logic [LO_BITS-1:0] s1_lo,
  output logic [ENTRY_W-1:0] s1_entry
);

  localparam logic [PAY_W-1:0] DEF_PAY = PAY_W'(DEFAULT_HOP);

  logic [ENTRY_W-1:0] t1_q;
  logic [DEPTH-1:0]   written;
  logic               written_q;

  dir_lpm_ram #(.DW(ENTRY_W), .AW(HI_BITS)) u_t1 (
    .clk   (clk),
    .we    (t1_we),
    .waddr (t1_widx),
    .wdata (t1_wdata),
    .re    (req_valid),
    .raddr (req_hi),
    .rdata (t1_q)
  );

  // Per-entry "loaded" marks stand in for a reset of the array itself.
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
    end else if (t1_we) begin
      written[t1_widx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_lo     <= '0;
      written_q <= 1'b0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_lo     <= req_lo;
        written_q <= written[req_hi];
      end
    end
  end

  assign s1_entry = written_q ? t1_q : {1'b1, DEF_PAY};

endmodule

// File: rtl/dir_lpm_stage2.sv
// Second-table access: block base from the pointer, offset from the address.
module dir_lpm_stage2 #(
  parameter int LO_BITS = 4,
  parameter int HOP_W   = 8,
  parameter int T2_AW   = 8,
  parameter int ENTRY_W = 9,
  localparam int PTR_W  = T2_AW - LO_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s1_valid,
  input  logic [LO_BITS-1:0] s1_lo,
  input  logic [ENTRY_W-1:0] s1_entry,
  input  logic               t2_we,
  input  logic [T2_AW-1:0]   t2_widx,
  input  logic [HOP_W-1:0]   t2_wdata,
  output logic               s2_valid,
  output logic               s2_direct,
  output logic [HOP_W-1:0]   s2_hop,
  output logic [HOP_W-1:0]   t2_hop
);

  logic             is_direct;
  logic [T2_AW-1:0] t2_raddr;

  assign is_direct = s1_entry[ENTRY_W-1];
  assign t2_raddr  = {s1_entry[PTR_W-1:0], s1_lo};

  dir_lpm_ram #(.DW(HOP_W), .AW(T2_AW)) u_t2 (
    .clk   (clk),
    .we    (t2_we),
    .waddr (t2_widx),
    .wdata (t2_wdata),
    .re    (s1_valid && !is_direct),
    .raddr (t2_raddr),
    .rdata (t2_hop)
  );

  // The direct hop rides alongside the second read so both paths align.
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid  <= 1'b0;
      s2_direct <= 1'b0;
      s2_hop    <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_direct <= is_direct;
        s2_hop    <= s1_entry[HOP_W-1:0];
      end
    end
  end

endmodule

// File: rtl/dir_lpm_resolve.sv
// Final selection and registered result.
module dir_lpm_resolve #(
  parameter int HOP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s2_valid,
  input  logic             s2_direct,
  input  logic [HOP_W-1:0] s2_hop,
  input  logic [HOP_W-1:0] t2_hop,
  output logic             res_valid,
  output logic [HOP_W-1:0] res_hop
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hop   <= '0;
    end else begin
      res_valid <= s2_valid;
      if (s2_valid) res_hop <= s2_direct ? s2_hop : t2_hop;
    end
  end

endmodule

// File: rtl/dir_lpm.sv
module dir_lpm
  import dir_lpm_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          HI_BITS     = 12,
  parameter int          LO_BITS     = 4,
  parameter int          HOP_W       = 8,
  parameter int          T2_DEPTH    = 256,
  parameter int unsigned DEFAULT_HOP = 0,
  localparam int T2_AW   = $clog2(T2_DEPTH),
  localparam int PTR_W   = T2_AW - LO_BITS,
  localparam int PAY_W   = imax(HOP_W, PTR_W),
  localparam int ENTRY_W = PAY_W + 1,
  localparam int IDX_W   = imax(HI_BITS, T2_AW)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               res_valid,
  output logic [HOP_W-1:0]   res_hop,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data
);

  logic [HI_BITS-1:0] req_hi;
  logic [LO_BITS-1:0] req_lo;
  logic               t1_we, t2_we;
  logic               s1_valid;
  logic [LO_BITS-1:0] s1_lo;
  logic [ENTRY_W-1:0] s1_entry;
  logic               s2_valid, s2_direct;
  logic [HOP_W-1:0]   s2_hop, t2_hop;
  logic               unused_bits;

  assign req_hi = req_addr[ADDR_W-1 -: HI_BITS];
  assign req_lo = req_addr[ADDR_W-HI_BITS-1 -: LO_BITS];
  assign t1_we  = wr_en && (wr_sel == TBL_FIRST);
  assign t2_we  = wr_en && (wr_sel == TBL_SECOND);

  // Address bits below the two index fields and unused write bits.
  assign unused_bits = ^{req_addr, wr_idx, wr_data};

  dir_lpm_stage1 #(
    .HI_BITS(HI_BITS), .LO_BITS(LO_BITS), .ENTRY_W(ENTRY_W),
    .DEFAULT_HOP(DEFAULT_HOP)
  ) u_stage1 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_hi(req_hi), .req_lo(req_lo),
    .t1_we(t1_we), .t1_widx(wr_idx[HI_BITS-1:0]), .t1_wdata(wr_data),
    .s1_valid(s1_valid), .s1_lo(s1_lo), .s1_entry(s1_entry)
  );

  dir_lpm_stage2 #(
    .LO_BITS(LO_BITS), .HOP_W(HOP_W), .T2_AW(T2_AW), .ENTRY_W(ENTRY_W)
  ) u_stage2 (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_lo(s1_lo), .s1_entry(s1_entry),
    .t2_we(t2_we), .t2_widx(wr_idx[T2_AW-1:0]), .t2_wdata(wr_data[HOP_W-1:0]),
    .s2_valid(s2_valid), .s2_direct(s2_direct), .s2_hop(s2_hop), .t2_hop(t2_hop)
  );

  dir_lpm_resolve #(.HOP_W(HOP_W)) u_resolve (
    .clk(clk), .rst(rst),
    .s2_valid(s2_valid), .s2_direct(s2_direct), .s2_hop(s2_hop), .t2_hop(t2_hop),
    .res_valid(res_valid), .res_hop(res_hop)
  );

endmodule

// File: rtl/dir_lpm_chk.sv
module dir_lpm_chk #(
  parameter int          HOP_W       = 8,
  parameter int unsigned DEFAULT_HOP = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             res_valid,
  input logic [HOP_W-1:0] res_hop,
  input logic             wr_en,
  input logic             wr_sel
);

  logic [1:0] cyc;
  logic       t1_touched;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc        <= '0;
      t1_touched <= 1'b0;
    end else begin
      if (cyc != 2'd3) cyc <= cyc + 2'd1;
      if (wr_en && !wr_sel) t1_touched <= 1'b1;
    end
  end

  // R4
  r4_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) |-> (res_valid == $past(req_valid, 3)));

  // R4
  r4_known_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(res_valid));

  // R1
  r1_default_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !t1_touched) |-> (res_hop == HOP_W'(DEFAULT_HOP)));

  // R8
  r8_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0 && !res_valid) |-> $stable(res_hop));

endmodule

bind dir_lpm dir_lpm_chk #(.HOP_W(HOP_W), .DEFAULT_HOP(DEFAULT_HOP)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .res_valid(res_valid),
  .res_hop(res_hop), .wr_en(wr_en), .wr_sel(wr_sel)
);

// File: tb/dir_lpm_tb.sv
`timescale 1ns/1ps
module dir_lpm_tb;

  localparam int HI = 12, LO = 4, HW = 8, EW = 9, IW = 12;
  localparam logic [7:0] DEF = 8'hA5;

  logic          clk = 0, rst = 1;
  logic          req_valid = 0;
  logic [31:0]   req_addr = '0;
  logic          res_valid;
  logic [HW-1:0] res_hop;
  logic          wr_en = 0, wr_sel = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [EW-1:0] wr_data = '0;

  int n_chk = 0, n_fail = 0;

  logic [EW-1:0] t1m [4096];
  logic          seenm [4096];
  logic [HW-1:0] t2m [256];

  always #5 clk = ~clk;

  dir_lpm #(.DEFAULT_HOP(DEF)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .res_valid(res_valid), .res_hop(res_hop), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [31:0] a);
    logic [EW-1:0] e;
    e = seenm[a[31:20]] ? t1m[a[31:20]] : {1'b1, DEF};
    if (e[EW-1]) return e[7:0];
    return t2m[{e[3:0], a[19:16]}];
  endfunction

  task automatic wr(input logic sel, input int idx, input logic [EW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (!sel) begin t1m[idx] = d; seenm[idx] = 1; end
    else t2m[idx] = d[7:0];
  endtask

  task automatic lookup(input string tag, input logic [31:0] a);
    logic [7:0] e;
    e = model(a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    check({tag, " valid"}, 32'(res_valid), 32'd1);
    check({tag, " hop"}, 32'(res_hop), 32'(e));
  endtask

  task automatic t_reset;
    check("R4 reset valid low", 32'(res_valid), 32'd0);
    lookup("R1 default a", 32'h0000_0000);
    lookup("R1 default b", 32'hFFF1_2345);
  endtask

  task automatic t_direct;
    wr(0, 12'h0C0, {1'b1, 8'h42});
    lookup("R2 direct", 32'h0C00_0000);
    lookup("R1 untouched neighbour", 32'h0C10_0000);
  endtask

  task automatic t_indirect;
    for (int i = 0; i < 16; i++) wr(1, 3 * 16 + i, EW'(8'h80 + i));
    wr(0, 12'h123, {1'b0, 8'h03});
    lookup("R3 offset 0", 32'h1230_0000);
    lookup("R3 offset 5", 32'h1235_0000);
    lookup("R3 offset 15", 32'h123F_0000);
  endtask

  task automatic t_ignore;
    lookup("R5 low bits zero", 32'h1235_0000);
    lookup("R5 low bits ones", 32'h1235_FFFF);
    lookup("R5 direct low bits", 32'h0C0F_ABCD);
  endtask

  task automatic t_latency;
    logic [7:0] e, held;
    e = model(32'h1237_0000);
    @(negedge clk); req_valid = 1; req_addr = 32'h1237_0000;
    @(negedge clk); req_valid = 0;
    check("R4 low at c+1", 32'(res_valid), 32'd0);
    @(negedge clk);
    check("R4 low at c+2", 32'(res_valid), 32'd0);
    @(negedge clk);
    check("R4 high at c+3", 32'(res_valid), 32'd1);
    check("R3 hop at c+3", 32'(res_hop), 32'(e));
    held = res_hop;
    @(negedge clk);
    check("R4 low at c+4", 32'(res_valid), 32'd0);
    check("R8 hop held", 32'(res_hop), 32'(held));
  endtask

  task automatic t_stream;
    logic [31:0] a [8];
    logic [7:0]  e [8];
    for (int i = 0; i < 8; i++) begin
      a[i] = (i % 2 == 0) ? {12'h123, 4'(i), 16'h0} : {12'h0C0 + 12'(i), 4'(i), 16'h1};
      e[i] = model(a[i]);
    end
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        check("R4 stream valid", 32'(res_valid), 32'd1);
        check("R4 stream hop", 32'(res_hop), 32'(e[i-3]));
      end
      req_valid = (i < 8);
      if (i < 8) req_addr = a[i];
    end
    @(negedge clk);
    check("R4 stream ends", 32'(res_valid), 32'd0);
  endtask

  task automatic t_collide;
    logic [7:0] e;
    e = model(32'h0C00_0000);
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0C00_0000;
    wr_en = 1; wr_sel = 0; wr_idx = 12'h0C0; wr_data = {1'b1, 8'h77};
    @(negedge clk);
    req_valid = 0; wr_en = 0;
    t1m[12'h0C0] = {1'b1, 8'h77};
    repeat (2) @(negedge clk);
    check("R6 old data on collision", 32'(res_hop), 32'(e));
    lookup("R6 new data after", 32'h0C00_0000);
  endtask

  task automatic t_select;
    wr(1, 12'h0C0, EW'(8'h99));
    lookup("R7 first table unchanged", 32'h0C00_0000);
    wr(0, 12'h200, {1'b0, 8'h0C});
    lookup("R7 second table written", 32'h2000_0000);
    lookup("R7 earlier block intact", 32'h1235_0000);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) seenm[i] = 0;
    for (int i = 0; i < 256; i++) t2m[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indirect();
    t_ignore();
    t_latency();
    t_stream();
    t_collide();
    t_select();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule